// File: doc/BRIEF.md
# Hash State Address Generator

This block produces the byte read and write addresses that a byte-serial hash coprocessor uses to walk one 256-byte block of its internal state. The state is a 4x4 grid of 16-byte words. Each word is itself a 4x4 byte array. All the transposed and rotated visiting orders the round needs come from two small counters: a 4-bit counter that steps by five modulo 16, and an 8-bit counter that steps by one. The bit fields of these two counters are rearranged differently for each access pattern.

An operation begins with a one-cycle `start` that carries a 2-bit access mode and clears both counters. After that, each cycle with `enable` high advances the walk by one step. A low `enable` freezes the walk, the address outputs and the write delay line. Every read address is paired with a write address that appears exactly seven enabled cycles later. This covers the latency of the datapath between the memory read and the write-back. Only the low eight address bits are produced here. Choosing which memory block the upper bits select is left to the surrounding logic.

Top module: `hash_state_addr_gen`

## Requirements
- R1: In mode 2'b00 (word substitution), read j (0..255) of an operation is at address 16*floor(j/16) + (5*j mod 16). The low nibble follows 0,5,10,15,4,9,14,3,... and the high nibble advances every 16 reads.
- R2: In mode 2'b00, the write address paired with read j is j itself, so 256 writes cover 0..255 in order.
- R3: In mode 2'b01 (big column mixing), read j is at 16*(5*j mod 16) + floor(j/16). Within each group of 16 reads the address grows by 80 modulo 256.
- R4: In mode 2'b01, the write paired with read j is at 16*(j mod 16) + floor(j/16). This is the read counter with its two nibbles swapped.
- R5: In mode 2'b10 (final fold), enabled cycles form 64 slots of 7 cycles each. In slot g, the first four cycles read addresses g, 64+g, 128+g and 192+g. The other three cycles issue no read.
- R6: In mode 2'b10, exactly one write is issued per slot, at address g (below 64). The last write lands in enabled cycle 448 counted from the start cycle, so a fold lasts 449 enabled cycles before done.
- R7: Each write address leaves the block exactly seven enabled cycles after the read it is paired with. `wrEn` is high only while such a delayed address is presented. In modes 2'b00 and 2'b01 every read has a paired write. In mode 2'b10 only the first read of each slot has one.
- R8: While `enable` is low, `rdValid` and `wrEn` stay low. Both address outputs hold their values, and no counter or delay stage moves. The seven-cycle delay counts enabled cycles only.
- R9: `done` is a single-cycle pulse in the first cycle after the last write has left. In modes 2'b00 and 2'b01 that is enabled cycle 263 of the operation. It is never high together with `rdValid` or `wrEn`.
- R10: A `start` with mode 2'b00, 2'b01 or 2'b10 clears both counters and the delay line and begins a new operation, even in the middle of a running one; pending writes of the aborted operation are dropped. A `start` with mode 2'b11 is ignored.
- R11: After reset, `rdValid`, `wrEn` and `done` are low until a valid start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new operation with the given mode |
| mode | input | 2 | Access pattern: 00 substitution, 01 big mixing, 10 fold, 11 unused |
| enable | input | 1 | Advance the walk this cycle |
| rdAddr | output | 8 | Byte read address within the state block |
| rdValid | output | 1 | rdAddr is a read to perform this cycle |
| wrAddr | output | 8 | Delayed byte write address |
| wrEn | output | 1 | wrAddr is a write to perform this cycle |
| done | output | 1 | One-cycle pulse after the last write of an operation |

## Verification
The walk is driven through the following patterns:

- **Each mode, enable held high.** This separates the three field arrangements of the counters from one another, and the two write orders from their read orders.
- **Big-mixing walk with periodic and long enable gaps.** This shows whether the delay line and the counters count enabled cycles or clock cycles.
- **Unused mode code.** This checks that the ignored start leaves the block idle.
- **Restart mid-walk into a different mode.** This checks that writes still in flight are discarded.
- **Start issued in the done cycle.** This checks that a following operation begins cleanly.

Each of these runs is compared on every clock against a reference that computes each expected address from the enabled-cycle index alone.

// File: rtl/hash_addr_pkg.sv
package hash_addr_pkg;

  typedef enum logic [1:0] {
    MODE_SUBW = 2'b00,
    MODE_BMIX = 2'b01,
    MODE_FOLD = 2'b10,
    MODE_NONE = 2'b11
  } accMode_e;

  // strobes from the control to the address datapath
  typedef struct packed {
    logic     clearAll;
    logic     cntAdvance;
    logic     pipeShift;
    logic     pushWrite;
    logic     readStrobe;
    accMode_e mode;
  } addrStrobe_t;

  // status from the datapath back to the control
  typedef struct packed {
    logic isReadSlot;
    logic isWriteSlot;
    logic isLastRead;
    logic pipeEmpty;
  } addrStatus_t;

endpackage

// File: rtl/hash_addr_datapath.sv
module hash_addr_datapath
  import hash_addr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DELAY      = 7,
  parameter int SMALL_STEP = 5,
  parameter int FOLD_SLOTS = 7,
  parameter int FOLD_READS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addrStrobe_t       strobe,
  output addrStatus_t       status,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrEn
);

  localparam int NIB = ADDR_W / 2;
  localparam int K_W = $clog2(FOLD_READS);
  localparam logic [NIB-1:0]    STEP_V       = NIB'(SMALL_STEP);
  localparam logic [NIB-1:0]    SLOT_LAST    = NIB'(FOLD_SLOTS - 1);
  localparam logic [NIB-1:0]    READ_LIM     = NIB'(FOLD_READS);
  localparam logic [ADDR_W-1:0] BMIX_STRIDE  = ADDR_W'(SMALL_STEP << NIB);

  logic [ADDR_W-1:0] bigCnt;
  logic [NIB-1:0]    smallCnt;
  logic [ADDR_W-1:0] wrNext;
  logic [DELAY-1:0]  pipeV;
  logic [ADDR_W-1:0] pipeA [DELAY];

  // counters: fold mode reuses the small counter as a slot counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bigCnt   <= '0;
      smallCnt <= '0;
    end else if (strobe.clearAll) begin
      bigCnt   <= '0;
      smallCnt <= '0;
    end else if (strobe.cntAdvance) begin
      if (strobe.mode == MODE_FOLD) begin
        if (smallCnt == SLOT_LAST) smallCnt <= '0;
        else                       smallCnt <= smallCnt + 1'b1;
        if (status.isReadSlot)     bigCnt   <= bigCnt + 1'b1;
      end else begin
        smallCnt <= smallCnt + STEP_V;
        bigCnt   <= bigCnt + 1'b1;
      end
    end
  end

  // field reshuffle per mode
  always_comb begin
    unique case (strobe.mode)
      MODE_BMIX: begin
        rdAddr = {smallCnt, bigCnt[ADDR_W-1:NIB]};
        wrNext = {bigCnt[NIB-1:0], bigCnt[ADDR_W-1:NIB]};
      end
      MODE_FOLD: begin
        rdAddr = {bigCnt[K_W-1:0], bigCnt[ADDR_W-1:K_W]};
        wrNext = {{K_W{1'b0}}, bigCnt[ADDR_W-1:K_W]};
      end
      default: begin
        rdAddr = {bigCnt[ADDR_W-1:NIB], smallCnt};
        wrNext = bigCnt;
      end
    endcase
  end

  always_comb begin
    if (strobe.mode == MODE_FOLD) begin
      status.isReadSlot  = (smallCnt < READ_LIM);
      status.isWriteSlot = (smallCnt == '0);
    end else begin
      status.isReadSlot  = 1'b1;
      status.isWriteSlot = 1'b1;
    end
    status.isLastRead = (&bigCnt) && status.isReadSlot;
    status.pipeEmpty  = ~|pipeV;
  end

  // write-address delay line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipeV <= '0;
      for (int s = 0; s < DELAY; s++) pipeA[s] <= '0;
    end else if (strobe.clearAll) begin
      pipeV <= '0;
    end else if (strobe.pipeShift) begin
      pipeV    <= {pipeV[DELAY-2:0], strobe.pushWrite};
      pipeA[0] <= wrNext;
      for (int s = 1; s < DELAY; s++) pipeA[s] <= pipeA[s-1];
    end
  end

  assign wrAddr = pipeA[DELAY-1];
  assign wrEn   = pipeV[DELAY-1] && strobe.pipeShift;

  // R1
  subw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.readStrobe && strobe.mode == MODE_SUBW && $past(strobe.readStrobe)
     && !$past(strobe.clearAll))
    |-> (rdAddr[NIB-1:0] == $past(rdAddr[NIB-1:0]) + STEP_V));

  // R3
  bmix_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.readStrobe && strobe.mode == MODE_BMIX && $past(strobe.readStrobe)
     && !$past(strobe.clearAll) && rdAddr[NIB-1:0] == $past(rdAddr[NIB-1:0]))
    |-> (rdAddr == $past(rdAddr) + BMIX_STRIDE));

  // R6
  fold_wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && strobe.mode == MODE_FOLD) |-> (wrAddr[ADDR_W-1 -: K_W] == '0));

  // R8
  hold_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.pipeShift && !strobe.clearAll) |=> $stable(wrAddr));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (rdAddr == '0 && !wrEn));

endmodule

// File: rtl/hash_addr_control.sv
module hash_addr_control
  import hash_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        enable,
  input  addrStatus_t status,
  output addrStrobe_t strobe,
  output logic        done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctlState_e;

  ctlState_e state;
  accMode_e  curMode;
  logic      startOk;
  logic      running;
  logic      busy;

  assign startOk = start && (accMode_e'(mode) != MODE_NONE);
  assign running = (state == ST_RUN);
  assign busy    = (state == ST_RUN) || (state == ST_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      curMode <= MODE_SUBW;
    end else if (startOk) begin
      state   <= ST_RUN;
      curMode <= accMode_e'(mode);
    end else begin
      unique case (state)
        ST_RUN:   if (enable && status.isLastRead) state <= ST_DRAIN;
        ST_DRAIN: if (status.pipeEmpty)             state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearAll   = startOk;
    strobe.cntAdvance = running && enable;
    strobe.pipeShift  = busy && enable;
    strobe.pushWrite  = running && enable && status.isWriteSlot;
    strobe.readStrobe = running && enable && status.isReadSlot;
    strobe.mode       = curMode;
  end

  assign done = (state == ST_DRAIN) && status.pipeEmpty;

  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/hash_state_addr_gen.sv
module hash_state_addr_gen
  import hash_addr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DELAY      = 7,
  parameter int SMALL_STEP = 5,
  parameter int FOLD_SLOTS = 7,
  parameter int FOLD_READS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              enable,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrEn,
  output logic              done
);

  addrStrobe_t strobe;
  addrStatus_t status;

  hash_addr_control ctl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .enable (enable),
    .status (status),
    .strobe (strobe),
    .done   (done)
  );

  hash_addr_datapath #(
    .ADDR_W     (ADDR_W),
    .DELAY      (DELAY),
    .SMALL_STEP (SMALL_STEP),
    .FOLD_SLOTS (FOLD_SLOTS),
    .FOLD_READS (FOLD_READS)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .status (status),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .wrEn   (wrEn)
  );

  assign rdValid = strobe.readStrobe;

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wrEn && !rdValid));

endmodule

// File: tb/hash_state_addr_gen_tb.sv
module hash_state_addr_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       enable = 1'b0;
  logic [7:0] rdAddr;
  logic       rdValid;
  logic [7:0] wrAddr;
  logic       wrEn;
  logic       done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R11 reset";

  // reference model state
  bit busy = 0;
  int curM = 0;
  int j = 0;

  always #4 clk = ~clk;

  hash_state_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .enable(enable),
    .rdAddr(rdAddr), .rdValid(rdValid), .wrAddr(wrAddr), .wrEn(wrEn), .done(done)
  );

  function automatic int endJ(int m);
    return (m == 2) ? 449 : 263;
  endfunction

  function automatic int expRd(int m, int k);
    if (m == 2) begin
      if ((k / 7) < 64 && (k % 7) < 4) return (k % 7) * 64 + k / 7;
      return -1;
    end
    if (k >= 256) return -1;
    if (m == 0) return (k / 16) * 16 + (5 * k) % 16;
    return ((5 * k) % 16) * 16 + k / 16;
  endfunction

  function automatic int expWr(int m, int k);
    int r = k - 7;            // R7: seven enabled cycles after the read
    if (r < 0) return -1;
    if (m == 2) begin
      if (r % 7 == 0 && r / 7 < 64) return r / 7;
      return -1;
    end
    if (r >= 256) return -1;
    if (m == 0) return r;
    return (r % 16) * 16 + r / 16;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d (mode=%0d j=%0d t=%0t)",
               req, phase, what, act, exp, curM, j, $time);
    end
  endtask

  task automatic compare();
    int er = busy ? expRd(curM, j) : -1;
    int ew = busy ? expWr(curM, j) : -1;
    string rTag = (curM == 0) ? "R1" : (curM == 1) ? "R3" : "R5";
    string wTag = (curM == 0) ? "R2" : (curM == 1) ? "R4" : "R6";
    if (!enable) begin rTag = "R8"; wTag = "R8"; end
    chk(rTag, "rdValid", int'(rdValid), int'(er >= 0 && enable));
    if (er >= 0) chk(rTag, "rdAddr", int'(rdAddr), er);
    chk("R7", "wrEn", int'(wrEn), int'(ew >= 0 && enable));
    if (ew >= 0) chk(wTag, "wrAddr", int'(wrAddr), ew);
    chk("R9", "done", int'(done), int'(busy && j == endJ(curM)));
  endtask

  task automatic modelStep();
    if (start && mode != 2'b11) begin
      busy = 1; curM = int'(mode); j = 0;
    end else if (busy) begin
      if (j == endJ(curM)) busy = 0;
      else if (enable) j++;
    end
  endtask

  task automatic cyc(input bit st, input bit [1:0] md, input bit en);
    @(negedge clk);
    compare();
    start = st; mode = md; enable = en;
    modelStep();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "rdValid in reset", int'(rdValid), 0);
    chk("R11", "wrEn in reset", int'(wrEn), 0);
    chk("R11", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 1);

    phase = "R1 R2 substitution";
    cyc(1, 0, 1);
    while (busy) cyc(0, 0, 1);
    repeat (2) cyc(0, 0, 1);

    phase = "R3 R4 R8 big mixing with stalls";
    cyc(1, 1, 1);
    for (int k = 0; busy; k++)
      cyc(0, 0, !((k % 5) == 3 || (k >= 100 && k < 112)));
    repeat (2) cyc(0, 0, 0);

    phase = "R5 R6 fold";
    cyc(1, 2, 1);
    while (busy) cyc(0, 0, 1);
    repeat (2) cyc(0, 0, 1);

    phase = "R10 unused mode ignored";
    cyc(1, 3, 1);
    repeat (15) cyc(0, 3, 1);

    phase = "R10 restart mid-walk";
    cyc(1, 0, 1);
    repeat (90) cyc(0, 0, 1);
    cyc(1, 2, 1);
    for (int k = 0; busy; k++) cyc(0, 0, (k % 7) != 2);
    repeat (2) cyc(0, 0, 1);

    phase = "R9 start in done cycle";
    cyc(1, 1, 1);
    while (!(busy && j == endJ(curM))) cyc(0, 0, 1);
    cyc(1, 0, 1);
    while (busy) cyc(0, 0, 1);
    repeat (3) cyc(0, 0, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog [%s] act=running exp=finished", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule